// File: doc/BRIEF.md
# Retimer Lock Qualification and Output Control

This controller sits beside the analog clock-recovery loop of a multi-rate serial video retimer and runs on the 27 MHz reference clock. Each cycle it receives a bit-rate class from an external rate estimator and a lock flag from the recovery loop. It also receives the user controls: a two-bit rate select, a force-bypass input, an active-low mute input and a clock/data select for the second output. From these it decides whether the measured rate is one the retimer supports and whether that rate fits the selected code. It then qualifies lock over a programmable window and drives the lock-detect flag, a registered SD/HD indicator and the bypass selection. It also drives the true and complement legs of two serial outputs. Each output is fed from the retimed bit, the raw input bit or the recovered clock, or is held muted.

A four-state machine does the qualification. ST_UNLOCKED is the reset and auto-bypass state; it moves to ST_QUALIFY when the loop reports lock at an acceptable rate. ST_QUALIFY latches the rate class and counts stable cycles. It falls back to ST_UNLOCKED on any mismatch and moves to ST_LOCKED when the count reaches the window. ST_LOCKED leaves for ST_UNLOCKED on the first mismatch. ST_FORCED is entered from any state while force-bypass is high, and it returns to ST_UNLOCKED once force-bypass is released. Rate class encoding on `rate_class_i`: 0 no signal, 1 SD 270 Mbps, 2 HD 1.483/1.485 Gbps, 3 3G 2.967/2.97 Gbps, 4 low unsupported (143/177 Mbps), 5 mid unsupported (360/540 Mbps), 6 harmonic of a supported rate, 7 spare. Only classes 1 to 3 are supported.

Top module: `rclk_lock_ctrl`

## Requirements
- R1: Rate select 2'b00 accepts any supported class. 2'b01 accepts only class 1 (SD). 2'b10 accepts only class 2 or 3 (HD/3G). A class rejected by the current code never lets lock_det_o assert.
- R2: While force_bypass_i is high, lock_det_o is low and bypass_o is high from the next clock edge on, whatever the loop lock and rate inputs are.
- R3: With force_bypass_i low, bypass_o is high whenever lock_det_o is low. Output lane 0 carries raw_bit_i in bypass and retimed_bit_i when locked.
- R4: Classes 0, 4, 5, 6 and 7 are never declared locked and always leave bypass_o high.
- R5: When mute_n_i is low, both output lanes are muted whatever the bypass and lock state.
- R6: With clk_sel_i high, lane 1 carries rec_clk_i and is also muted while bypass_o is high. With clk_sel_i low, lane 1 carries the same bit as lane 0.
- R7: A muted lane drives out_p_o low and out_n_o high and stays static while its sources toggle. An unmuted lane drives complementary legs.
- R8: sd_hd_o goes high only on the edge on which lock_det_o asserts with class 1 latched. It goes low on the same edge on which lock_det_o falls, and it is never high while lock_det_o is low.
- R9: lock_det_o rises on the (LOCK_CNT+1)th consecutive rising edge at which the loop is locked, the class is acceptable and the class is unchanged. It falls at the first edge at which any of these fails.
- R10: Rate select 2'b11 behaves as automatic detection (2'b00).
- R11: Synchronous active-high reset gives lock_det_o low, sd_hd_o low and bypass_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_class_i | input | 3 | Measured bit-rate class from the estimator |
| loop_lock_i | input | 1 | Lock flag from the clock-recovery loop |
| rate_sel_i | input | 2 | User rate select code |
| force_bypass_i | input | 1 | Force the retimer into bypass |
| mute_n_i | input | 1 | Active-low mute of both outputs |
| clk_sel_i | input | 1 | Lane 1 source: 1 recovered clock, 0 data |
| retimed_bit_i | input | 1 | Retimed serial bit |
| raw_bit_i | input | 1 | Unretimed input bit |
| rec_clk_i | input | 1 | Recovered serial clock level |
| lock_det_o | output | 1 | Qualified lock detect |
| sd_hd_o | output | 1 | High for SD lock, low otherwise |
| bypass_o | output | 1 | Retimer bypass selection |
| out_p_o | output | NUM_LANE | True legs of the serial outputs |
| out_n_o | output | NUM_LANE | Complement legs of the serial outputs |

## Verification
The properties take for granted that every input is synchronous to the reference clock and holds a defined level at each sampled edge. They also assume that the serial sources feeding the output lanes are plain levels sampled by the same clock. The bench drives all inputs on the falling edge, and it keeps the rate class, the loop lock and the rate select constant through each qualification window unless a test changes one on purpose to provoke loss of lock. The lock window is shortened by parameter override so that each window fits in a few cycles.

// File: rtl/rclk_pkg.sv
package rclk_pkg;

    typedef enum logic [2:0] {
        RC_NONE     = 3'd0,
        RC_SD       = 3'd1,
        RC_HD       = 3'd2,
        RC_3G       = 3'd3,
        RC_LOW_BAD  = 3'd4,
        RC_MID_BAD  = 3'd5,
        RC_HARMONIC = 3'd6,
        RC_SPARE    = 3'd7
    } rate_class_t;

    typedef enum logic [1:0] {
        SEL_AUTO  = 2'b00,
        SEL_SD    = 2'b01,
        SEL_HD3G  = 2'b10,
        SEL_SPARE = 2'b11
    } rate_sel_t;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_QUALIFY  = 2'd1,
        ST_LOCKED   = 2'd2,
        ST_FORCED   = 2'd3
    } lock_state_t;

endpackage

// File: rtl/rclk_rate_qual.sv
module rclk_rate_qual
    import rclk_pkg::*;
(
    input  logic [2:0] rate_class_i,
    input  logic [1:0] rate_sel_i,
    output logic       rate_ok_o
);

    logic supported;
    logic fits_code;

    always_comb begin
        unique case (rate_class_t'(rate_class_i))
            RC_SD, RC_HD, RC_3G: supported = 1'b1;
            default:             supported = 1'b0;
        endcase
    end

    always_comb begin
        unique case (rate_sel_t'(rate_sel_i))
            SEL_SD:   fits_code = (rate_class_i == RC_SD);
            SEL_HD3G: fits_code = (rate_class_i == RC_HD) || (rate_class_i == RC_3G);
            default:  fits_code = 1'b1;  // auto and spare code
        endcase
    end

    assign rate_ok_o = supported && fits_code;

endmodule

// File: rtl/rclk_lock_fsm.sv
module rclk_lock_fsm
    import rclk_pkg::*;
#(
    parameter int LOCK_CNT = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       force_bypass_i,
    input  logic       loop_lock_i,
    input  logic       rate_ok_i,
    input  logic [2:0] rate_class_i,
    output logic       lock_det_o,
    output logic       sd_hd_o,
    output logic       bypass_o
);

    localparam int CNT_W = $clog2(LOCK_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CNT - 1);

    lock_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       held_q, held_d;
    logic             sdhd_q, sdhd_d;
    logic             cand;
    logic             same;

    assign cand = loop_lock_i && rate_ok_i;
    assign same = (rate_class_i == held_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        held_d  = held_q;
        sdhd_d  = sdhd_q;
        if (force_bypass_i) begin
            state_d = ST_FORCED;
            sdhd_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_UNLOCKED: begin
                    if (cand) begin
                        state_d = ST_QUALIFY;
                        cnt_d   = '0;
                        held_d  = rate_class_i;
                    end
                end
                ST_QUALIFY: begin
                    if (!cand || !same) begin
                        state_d = ST_UNLOCKED;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = ST_LOCKED;
                        sdhd_d  = (held_q == RC_SD);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (!cand || !same) begin
                        state_d = ST_UNLOCKED;
                        sdhd_d  = 1'b0;
                    end
                end
                ST_FORCED: begin
                    state_d = ST_UNLOCKED;
                end
                default: state_d = ST_UNLOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNLOCKED;
            cnt_q   <= '0;
            held_q  <= '0;
            sdhd_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            held_q  <= held_d;
            sdhd_q  <= sdhd_d;
        end
    end

    always_comb begin
        lock_det_o = 1'b0;
        bypass_o   = 1'b1;
        unique case (state_q)
            ST_LOCKED: begin
                lock_det_o = 1'b1;
                bypass_o   = 1'b0;
            end
            ST_UNLOCKED, ST_QUALIFY, ST_FORCED: begin
                lock_det_o = 1'b0;
                bypass_o   = 1'b1;
            end
            default: ;
        endcase
        sd_hd_o = sdhd_q;
    end

endmodule

// File: rtl/rclk_out_mux.sv
module rclk_out_mux #(
    parameter int NUM_LANE = 2
) (
    input  logic                mute_n_i,
    input  logic                clk_sel_i,
    input  logic                bypass_i,
    input  logic                retimed_bit_i,
    input  logic                raw_bit_i,
    input  logic                rec_clk_i,
    output logic [NUM_LANE-1:0] out_p_o,
    output logic [NUM_LANE-1:0] out_n_o
);

    logic data_bit;
    assign data_bit = bypass_i ? raw_bit_i : retimed_bit_i;

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        logic lane_bit;
        logic lane_mute;
        if (g == 0) begin : g_primary
            assign lane_bit  = data_bit;
            assign lane_mute = !mute_n_i;
        end else begin : g_second
            assign lane_bit  = clk_sel_i ? rec_clk_i : data_bit;
            assign lane_mute = !mute_n_i || (clk_sel_i && bypass_i);
        end
        assign out_p_o[g] = lane_mute ? 1'b0 : lane_bit;
        assign out_n_o[g] = lane_mute ? 1'b1 : !lane_bit;
    end

endmodule

// File: rtl/rclk_lock_ctrl.sv
module rclk_lock_ctrl #(
    parameter int LOCK_CNT = 1024,
    parameter int NUM_LANE = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          rate_class_i,
    input  logic                loop_lock_i,
    input  logic [1:0]          rate_sel_i,
    input  logic                force_bypass_i,
    input  logic                mute_n_i,
    input  logic                clk_sel_i,
    input  logic                retimed_bit_i,
    input  logic                raw_bit_i,
    input  logic                rec_clk_i,
    output logic                lock_det_o,
    output logic                sd_hd_o,
    output logic                bypass_o,
    output logic [NUM_LANE-1:0] out_p_o,
    output logic [NUM_LANE-1:0] out_n_o
);

    logic rate_ok;

    rclk_rate_qual u_qual (
        .rate_class_i (rate_class_i),
        .rate_sel_i   (rate_sel_i),
        .rate_ok_o    (rate_ok)
    );

    rclk_lock_fsm #(.LOCK_CNT(LOCK_CNT)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .force_bypass_i (force_bypass_i),
        .loop_lock_i    (loop_lock_i),
        .rate_ok_i      (rate_ok),
        .rate_class_i   (rate_class_i),
        .lock_det_o     (lock_det_o),
        .sd_hd_o        (sd_hd_o),
        .bypass_o       (bypass_o)
    );

    rclk_out_mux #(.NUM_LANE(NUM_LANE)) u_mux (
        .mute_n_i      (mute_n_i),
        .clk_sel_i     (clk_sel_i),
        .bypass_i      (bypass_o),
        .retimed_bit_i (retimed_bit_i),
        .raw_bit_i     (raw_bit_i),
        .rec_clk_i     (rec_clk_i),
        .out_p_o       (out_p_o),
        .out_n_o       (out_n_o)
    );

endmodule

// File: rtl/rclk_lock_ctrl_chk.sv
module rclk_lock_ctrl_chk #(
    parameter int NUM_LANE = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          rate_class_i,
    input logic                loop_lock_i,
    input logic [1:0]          rate_sel_i,
    input logic                force_bypass_i,
    input logic                mute_n_i,
    input logic                clk_sel_i,
    input logic                retimed_bit_i,
    input logic                raw_bit_i,
    input logic                rec_clk_i,
    input logic                lock_det_o,
    input logic                sd_hd_o,
    input logic                bypass_o,
    input logic [NUM_LANE-1:0] out_p_o,
    input logic [NUM_LANE-1:0] out_n_o
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R11: assert (!lock_det_o && !sd_hd_o && bypass_o)
                else $error("reset state wrong");
        end
    end

    assert_sd_code_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (rate_sel_i == 2'b01 && rate_class_i != 3'd1) |=> !lock_det_o);

    assert_force_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        force_bypass_i |=> (!lock_det_o && bypass_o));

    assert_loop_unlock_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        !loop_lock_i |=> bypass_o);

    assert_unsupported_R4: assert property (@(posedge clk) disable iff (rst)
        (rate_class_i == 3'd0 || rate_class_i >= 3'd4) |=> (!lock_det_o && bypass_o));

    assert_sdhd_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
        sd_hd_o |-> lock_det_o);

    assert_lock_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_det_o) |-> $past(loop_lock_i));

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane_chk
        assert_mute_static_R5: assert property (@(posedge clk) disable iff (rst)
            !mute_n_i |-> (out_p_o[g] == 1'b0 && out_n_o[g] == 1'b1));
        assert_legs_opposite_R7: assert property (@(posedge clk) disable iff (rst)
            out_p_o[g] != out_n_o[g]);
        if (g > 0) begin : g_sec
            assert_clock_bypass_mute_R6: assert property (@(posedge clk) disable iff (rst)
                (clk_sel_i && bypass_o) |-> (out_p_o[g] == 1'b0 && out_n_o[g] == 1'b1));
        end
    end

endmodule

bind rclk_lock_ctrl rclk_lock_ctrl_chk #(.NUM_LANE(NUM_LANE)) u_chk (.*);

// File: tb/test_rclk_lock_ctrl.sv
module test_rclk_lock_ctrl;

    localparam int LOCK_CNT = 4;
    localparam int NUM_LANE = 2;
    localparam int NVEC = 13;

    logic                clk = 1'b0;
    logic                rst;
    logic [2:0]          rate_class_i;
    logic                loop_lock_i;
    logic [1:0]          rate_sel_i;
    logic                force_bypass_i;
    logic                mute_n_i;
    logic                clk_sel_i;
    logic                retimed_bit_i;
    logic                raw_bit_i;
    logic                rec_clk_i;
    logic                lock_det_o;
    logic                sd_hd_o;
    logic                bypass_o;
    logic [NUM_LANE-1:0] out_p_o;
    logic [NUM_LANE-1:0] out_n_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rclk_lock_ctrl #(.LOCK_CNT(LOCK_CNT), .NUM_LANE(NUM_LANE)) i_rclk_lock_ctrl (.*);

    // {rate_sel[1:0], class[2:0], loop_lock, exp_lock, exp_sdhd}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b00_001_1_1_1,  // R1 auto, SD
        8'b00_010_1_1_0,  // R1 auto, HD
        8'b00_011_1_1_0,  // R1 auto, 3G
        8'b00_001_0_0_0,  // R3 loop unlocked
        8'b00_100_1_0_0,  // R4 143/177 class
        8'b00_101_1_0_0,  // R4 360/540 class
        8'b00_110_1_0_0,  // R4 harmonic
        8'b00_000_1_0_0,  // R4 no signal
        8'b01_001_1_1_1,  // R1 forced SD, SD
        8'b01_010_1_0_0,  // R1 forced SD, HD rejected
        8'b10_011_1_1_0,  // R1 forced HD/3G, 3G
        8'b10_001_1_0_0,  // R1 forced HD/3G, SD rejected
        8'b11_001_1_1_1   // R10 spare code as auto
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        rate_class_i = 3'd1;
        loop_lock_i = 1'b1;
        rate_sel_i = 2'b00;
        force_bypass_i = 1'b0;
        mute_n_i = 1'b1;
        clk_sel_i = 1'b0;
        retimed_bit_i = 1'b1;
        raw_bit_i = 1'b0;
        rec_clk_i = 1'b1;
        edges(6);
        // R11: reset holds unlocked even with good inputs
        chk("R11 lock", {31'b0, lock_det_o}, 0);
        chk("R11 sdhd", {31'b0, sd_hd_o}, 0);
        chk("R11 bypass", {31'b0, bypass_o}, 1);

        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            rate_sel_i   = VEC[i][7:6];
            rate_class_i = VEC[i][5:3];
            loop_lock_i  = VEC[i][2];
            edges(LOCK_CNT + 1);
            chk($sformatf("R1/R4/R10 vec%0d lock", i), {31'b0, lock_det_o}, {31'b0, VEC[i][1]});
            chk($sformatf("R8 vec%0d sdhd", i), {31'b0, sd_hd_o}, {31'b0, VEC[i][0]});
            chk($sformatf("R3 vec%0d bypass", i), {31'b0, bypass_o}, {31'b0, !VEC[i][1]});
        end

        // R9: window timing
        do_reset();
        rate_sel_i = 2'b00; rate_class_i = 3'd2; loop_lock_i = 1'b1;
        edges(LOCK_CNT);
        chk("R9 not yet locked", {31'b0, lock_det_o}, 0);
        edges(1);
        chk("R9 locked on window", {31'b0, lock_det_o}, 1);
        loop_lock_i = 1'b0;
        edges(1);
        chk("R9 drop on loop unlock", {31'b0, lock_det_o}, 0);

        // R9: class glitch during qualification restarts window
        loop_lock_i = 1'b1;
        edges(2);
        rate_class_i = 3'd3;
        edges(LOCK_CNT);
        chk("R9 restart after class change", {31'b0, lock_det_o}, 0);
        edges(2);
        chk("R9 locked after restart", {31'b0, lock_det_o}, 1);

        // R8: SD lock then loss clears indicator
        do_reset();
        rate_class_i = 3'd1;
        edges(LOCK_CNT + 1);
        chk("R8 sd lock", {31'b0, sd_hd_o}, 1);
        rate_class_i = 3'd2;
        edges(1);
        chk("R8 sd cleared on loss", {31'b0, sd_hd_o}, 0);
        chk("R8 lock cleared", {31'b0, lock_det_o}, 0);

        // R3 data path, R6 clock mode when locked
        do_reset();
        rate_class_i = 3'd1; retimed_bit_i = 1'b1; raw_bit_i = 1'b0;
        clk_sel_i = 1'b1; rec_clk_i = 1'b1;
        edges(LOCK_CNT + 1);
        chk("R3 lane0 retimed", {30'b0, out_p_o[0], out_n_o[0]}, 2'b10);
        chk("R6 lane1 clock", {30'b0, out_p_o[1], out_n_o[1]}, 2'b10);
        rec_clk_i = 1'b0;
        #1;
        chk("R6 lane1 clock low", {30'b0, out_p_o[1], out_n_o[1]}, 2'b01);

        // R2: force bypass
        force_bypass_i = 1'b1;
        edges(1);
        chk("R2 lock low", {31'b0, lock_det_o}, 0);
        chk("R2 bypass high", {31'b0, bypass_o}, 1);
        chk("R3 lane0 raw", {30'b0, out_p_o[0], out_n_o[0]}, 2'b01);
        rec_clk_i = 1'b1;
        #1;
        chk("R6 lane1 muted in bypass", {30'b0, out_p_o[1], out_n_o[1]}, 2'b01);
        edges(LOCK_CNT + 3);
        chk("R2 lock stays low", {31'b0, lock_det_o}, 0);
        clk_sel_i = 1'b0; raw_bit_i = 1'b1;
        #1;
        chk("R6 lane1 data copy", {30'b0, out_p_o[1], out_n_o[1]}, 2'b10);
        chk("R3 lane0 raw high", {30'b0, out_p_o[0], out_n_o[0]}, 2'b10);
        force_bypass_i = 1'b0;
        edges(LOCK_CNT + 2);
        chk("R2 relock after release", {31'b0, lock_det_o}, 1);

        // R5/R7: mute overrides, static under toggling
        mute_n_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            retimed_bit_i = k[0];
            raw_bit_i = k[1];
            rec_clk_i = k[0];
            clk_sel_i = k[1];
            #1;
            chk("R5 R7 muted legs", {28'b0, out_p_o, out_n_o}, 4'b0011);
            edges(1);
        end
        mute_n_i = 1'b1;
        clk_sel_i = 1'b0;
        retimed_bit_i = 1'b0;
        #1;
        chk("R7 unmuted complement", {28'b0, out_p_o, out_n_o}, 4'b0011);
        retimed_bit_i = 1'b1;
        #1;
        chk("R7 unmuted true", {28'b0, out_p_o, out_n_o}, 4'b1100);

        finish_run();
    end

endmodule